// File: doc/BRIEF.md
# Context-Tagged Multi-Size Translation Lookaside Buffer

This block is a fully associative translation buffer. Each slot holds a virtual page tag, a 13-bit context, a physical page number, a page-size code and a set of attribute flags. Every lookup is compared against all slots in parallel. Each slot is compared under its own page-size mask, and the block returns the translated physical page together with the access rights it grants. If the lookup fails, the block reports one of three outcomes: a miss, an access-rule fault or a write-protection fault.

The lookup picks its context in one of three ways: the primary context, the secondary context, or the nucleus context, which is always zero. Data-side rules cover privileged pages, no-fault loads and pages with side effects. Instruction-side rules check privilege only. On every miss or failed access the block loads a tag-access register that a refill handler can read. Failed accesses also update a fault status word, and that word records when an earlier fault was never cleared. Slots are loaded through a single write port. Choosing a victim slot and fetching entries from memory are handled outside the block.

Top module: `xlate_tlb`

## Requirements
- R1: A slot matches when its valid flag (bit 0 of `wr_flags`) is set, its global flag (bit 1) is set or its context equals the lookup context, and the lookup VA equals the slot tag under the slot's size mask. Size codes 0, 1, 2 and 3 give 8 KB, 64 KB, 512 KB and 4 MB pages, so 0, 3, 6 or 9 extra low tag bits are ignored.
- R2: On a hit, `res_ppn` (physical address bits [40:13]) takes the slot's page-number bits above the size mask and the VA bits below it.
- R3: `lk_ctx_sel` picks the data context: 0 gives `primary_ctx`, 1 gives `secondary_ctx`, and 2 or 3 give the nucleus context 0. An instruction fetch (`lk_kind`=3) uses context 0 when `lk_tl_nz` is high and `primary_ctx` otherwise.
- R4: When several slots match, the lowest-numbered slot is the one used and reported in `res_idx`.
- R5: Access kinds are encoded as 0 load, 1 store, 2 no-fault load and 3 fetch. A fault is raised for each of these conditions:
  - a user access to a page with the privileged flag (bit 2);
  - a no-fault load to a page with the side-effect flag (bit 5);
  - a load or store to a page with the no-fault-only flag (bit 4).
  A fetch checks only the privilege rule. Fault-type bits 7, 8 and 9 of `fsr` record these three causes and may be set together.
- R6: A store to a page without the writable flag (bit 3) that raises no fault is reported on `res_prot`, not on `res_fault`.
- R7: On a miss, fault or protection fault, `tag_access` becomes the VA with its low 13 bits cleared, ORed with the lookup context. A clean hit leaves it unchanged.
- R8: A clean hit sets bit `res_idx` of `used_bits`. Writing a slot clears that slot's used bit.
- R9: `res_perm` has bit 0 for read, bit 1 for write and bit 2 for execute. A clean data hit grants read, plus write when the slot is writable. A clean fetch hit grants execute only. All other outcomes grant nothing. `res_ie` copies flag bit 6 on a clean hit.
- R10: On a fault or protection fault, `fsr` is loaded with the following fields:
  - bit 0: valid;
  - bit 1: overflow, set when bit 0 was already set;
  - bit 2: store;
  - bit 3: no-fault load;
  - bit 4: `lk_privmode`;
  - bits 6:5: context class (0 primary, 1 secondary, 2 nucleus);
  - bits 9:7: fault type.
  `fsr_clr` zeroes `fsr`. A miss leaves `fsr` unchanged.
- R11: Exactly one of `res_hit`, `res_fault`, `res_prot` and `res_miss` is high in the cycle after each lookup, together with `res_valid`. A slot write is visible to lookups from the next cycle on.
- R12: After reset every slot is invalid, and all outputs, `tag_access`, `fsr` and `used_bits` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load a slot |
| wr_idx | input | 6 | Slot to load |
| wr_vpn | input | 51 | Virtual tag, VA bits [63:13] |
| wr_ctx | input | 13 | Slot context |
| wr_ppn | input | 28 | Physical page, PA bits [40:13] |
| wr_size | input | 2 | Page size code |
| wr_flags | input | 7 | Valid, global, privileged, writable, no-fault-only, side-effect, invert-endian |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 64 | Lookup virtual address |
| lk_kind | input | 2 | Access kind |
| lk_user | input | 1 | Access made in user mode |
| lk_privmode | input | 1 | Processor privileged state, recorded on fault |
| lk_ctx_sel | input | 2 | Data context select |
| lk_tl_nz | input | 1 | Trap level above zero |
| primary_ctx | input | 13 | Primary context |
| secondary_ctx | input | 13 | Secondary context |
| fsr_clr | input | 1 | Clear fault status |
| res_valid | output | 1 | Lookup result present |
| res_hit | output | 1 | Clean hit |
| res_fault | output | 1 | Access-rule fault |
| res_prot | output | 1 | Write-protection fault |
| res_miss | output | 1 | No slot matched |
| res_idx | output | 6 | Matched slot |
| res_ppn | output | 28 | Translated PA bits [40:13] |
| res_perm | output | 3 | Granted rights: exec, write, read |
| res_ie | output | 1 | Invert-endian attribute of the hit |
| tag_access | output | 64 | Faulting page and context |
| fsr | output | 10 | Fault status word |
| used_bits | output | 64 | Per-slot used flags |

## Verification
The table is first loaded with hand-placed slots to test each rule on its own:
- contexts that differ and a global slot that ignores the context;
- a 4 MB page, where low VA bits must pass through to the physical page;
- two slots with the same tag, where the lower index must win;
- every pairing of access kind with the privileged, side-effect, no-fault-only and read-only flags;
- the secondary, nucleus and trap-level context paths.

Two faults in a row, and then a clear, separate overflow from a fresh fault. After that the table is filled with random slots whose tags lie close together in a small region. Random lookups are aimed near those tags, so that different page sizes, overlapping matches, context mismatches and every access kind mix. A bench model predicts each outcome, page number, rights, tag-access value, status word and used vector.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
   localparam int FLAG_W = 7;
   localparam int FL_VALID = 0;
   localparam int FL_GLB   = 1;
   localparam int FL_PRIV  = 2;
   localparam int FL_WR    = 3;
   localparam int FL_NFO   = 4;
   localparam int FL_SIDE  = 5;
   localparam int FL_IE    = 6;

   localparam int FSR_W = 10;
   localparam int FS_VALID = 0;
   localparam int FS_OVF   = 1;
   localparam int FS_STORE = 2;
   localparam int FS_NF    = 3;
   localparam int FS_PM    = 4;
   localparam int FS_CLS   = 5;
   localparam int FS_FT    = 7;

   typedef enum logic [1:0] {
      ACC_LOAD = 2'd0, ACC_STORE = 2'd1, ACC_NFLOAD = 2'd2, ACC_FETCH = 2'd3
   } acc_kind_e;

   typedef enum logic [1:0] {
      CLS_PRIMARY = 2'd0, CLS_SECONDARY = 2'd1, CLS_NUCLEUS = 2'd2
   } ctx_cls_e;

   // ones in the tag bits that a page of this size ignores
   function automatic logic [8:0] size_lomask(input logic [1:0] sz);
      case (sz)
         2'd0:    return 9'h000;
         2'd1:    return 9'h007;
         2'd2:    return 9'h03f;
         default: return 9'h1ff;
      endcase
   endfunction
endpackage

// File: rtl/tlbx_match.sv
module tlbx_match
   import tlbx_pkg::*;
#(
   parameter int TAG_W = 51,
   parameter int CTX_W = 13
) (
   input  logic [TAG_W-1:0] tag,
   input  logic [CTX_W-1:0] ctx,
   input  logic [1:0]       size,
   input  logic             valid,
   input  logic             glb,
   input  logic [TAG_W-1:0] va_pg,
   input  logic [CTX_W-1:0] lk_ctx,
   output logic             hit
);
   logic [TAG_W-1:0] lo;
   always_comb begin
      lo  = {{(TAG_W-9){1'b0}}, size_lomask(size)};
      hit = valid && (glb || (ctx == lk_ctx)) && (((tag ^ va_pg) & ~lo) == '0);
   end
endmodule

// File: rtl/tlbx_pick.sv
module tlbx_pick #(
   parameter int N  = 64,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      any = |req;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/tlbx_rules.sv
module tlbx_rules
   import tlbx_pkg::*;
(
   input  logic [1:0]        kind,
   input  logic              user,
   input  logic [FLAG_W-1:0] fl,
   output logic              fault,
   output logic              prot,
   output logic [2:0]        ftype,
   output logic [2:0]        perm
);
   logic is_fetch;
   always_comb begin
      is_fetch = (kind == ACC_FETCH);
      ftype[0] = user && fl[FL_PRIV];
      ftype[1] = (kind == ACC_NFLOAD) && fl[FL_SIDE];
      ftype[2] = ((kind == ACC_LOAD) || (kind == ACC_STORE)) && fl[FL_NFO];
      fault    = |ftype;
      prot     = !fault && (kind == ACC_STORE) && !fl[FL_WR];
      if (fault || prot)  perm = 3'b000;
      else if (is_fetch)  perm = 3'b100;
      else                perm = {1'b0, fl[FL_WR], 1'b1};
   end
endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb
   import tlbx_pkg::*;
#(
   parameter int ENTRIES    = 64,
   parameter int VA_W       = 64,
   parameter int PA_W       = 41,
   parameter int PAGE_SHIFT = 13,
   parameter int CTX_W      = 13,
   localparam int IDX_W = $clog2(ENTRIES),
   localparam int TAG_W = VA_W - PAGE_SHIFT,
   localparam int PPN_W = PA_W - PAGE_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_vpn,
   input  logic [CTX_W-1:0]  wr_ctx,
   input  logic [PPN_W-1:0]  wr_ppn,
   input  logic [1:0]        wr_size,
   input  logic [FLAG_W-1:0] wr_flags,
   input  logic              lk_valid,
   input  logic [VA_W-1:0]   lk_va,
   input  logic [1:0]        lk_kind,
   input  logic              lk_user,
   input  logic              lk_privmode,
   input  logic [1:0]        lk_ctx_sel,
   input  logic              lk_tl_nz,
   input  logic [CTX_W-1:0]  primary_ctx,
   input  logic [CTX_W-1:0]  secondary_ctx,
   input  logic              fsr_clr,
   output logic              res_valid,
   output logic              res_hit,
   output logic              res_fault,
   output logic              res_prot,
   output logic              res_miss,
   output logic [IDX_W-1:0]  res_idx,
   output logic [PPN_W-1:0]  res_ppn,
   output logic [2:0]        res_perm,
   output logic              res_ie,
   output logic [VA_W-1:0]   tag_access,
   output logic [FSR_W-1:0]  fsr,
   output logic [ENTRIES-1:0] used_bits
);
   if (TAG_W <= 9 || PPN_W <= 9 || CTX_W > PAGE_SHIFT || ENTRIES < 2 || PA_W > VA_W) begin : g_bad_cfg
      $error("xlate_tlb: unsupported parameter combination");
   end

   logic [TAG_W-1:0]  tag_q   [ENTRIES];
   logic [CTX_W-1:0]  ctx_q   [ENTRIES];
   logic [PPN_W-1:0]  ppn_q   [ENTRIES];
   logic [1:0]        size_q  [ENTRIES];
   logic [FLAG_W-1:0] flags_q [ENTRIES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) begin
            tag_q[i]   <= '0;
            ctx_q[i]   <= '0;
            ppn_q[i]   <= '0;
            size_q[i]  <= '0;
            flags_q[i] <= '0;
         end
      end else if (wr_en) begin
         tag_q[wr_idx]   <= wr_vpn;
         ctx_q[wr_idx]   <= wr_ctx;
         ppn_q[wr_idx]   <= wr_ppn;
         size_q[wr_idx]  <= wr_size;
         flags_q[wr_idx] <= wr_flags;
      end
   end

   // context selection
   logic [TAG_W-1:0] va_pg;
   logic [1:0]       cls;
   logic [CTX_W-1:0] eff_ctx;
   always_comb begin
      va_pg = lk_va[VA_W-1:PAGE_SHIFT];
      if (lk_kind == ACC_FETCH) cls = lk_tl_nz ? CLS_NUCLEUS : CLS_PRIMARY;
      else if (lk_ctx_sel == 2'd0) cls = CLS_PRIMARY;
      else if (lk_ctx_sel == 2'd1) cls = CLS_SECONDARY;
      else cls = CLS_NUCLEUS;
      case (cls)
         CLS_PRIMARY:   eff_ctx = primary_ctx;
         CLS_SECONDARY: eff_ctx = secondary_ctx;
         default:       eff_ctx = '0;
      endcase
   end

   // parallel compare
   logic [ENTRIES-1:0] hit_vec;
   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      tlbx_match #(.TAG_W(TAG_W), .CTX_W(CTX_W)) u_match (
         .tag    (tag_q[g]),
         .ctx    (ctx_q[g]),
         .size   (size_q[g]),
         .valid  (flags_q[g][FL_VALID]),
         .glb    (flags_q[g][FL_GLB]),
         .va_pg  (va_pg),
         .lk_ctx (eff_ctx),
         .hit    (hit_vec[g])
      );
   end

   logic             any_hit;
   logic [IDX_W-1:0] pick;
   tlbx_pick #(.N(ENTRIES), .IW(IDX_W)) u_pick (.req(hit_vec), .any(any_hit), .idx(pick));

   logic [FLAG_W-1:0] sel_fl;
   logic              r_fault, r_prot;
   logic [2:0]        r_ft, r_perm;
   assign sel_fl = flags_q[pick];

   tlbx_rules u_rules (
      .kind  (lk_kind),
      .user  (lk_user),
      .fl    (sel_fl),
      .fault (r_fault),
      .prot  (r_prot),
      .ftype (r_ft),
      .perm  (r_perm)
   );

   logic [PPN_W-1:0] lo_p, merged_ppn;
   logic             clean;
   logic [FSR_W-1:0] fsr_n;
   logic [VA_W-1:0]  ta_n;
   always_comb begin
      lo_p       = {{(PPN_W-9){1'b0}}, size_lomask(size_q[pick])};
      merged_ppn = (ppn_q[pick] & ~lo_p) | (va_pg[PPN_W-1:0] & lo_p);
      clean      = any_hit && !r_fault && !r_prot;
      ta_n       = {va_pg, {PAGE_SHIFT{1'b0}}} | VA_W'(eff_ctx);
      fsr_n              = '0;
      fsr_n[FS_VALID]    = 1'b1;
      fsr_n[FS_OVF]      = fsr[FS_VALID] && !fsr_clr;
      fsr_n[FS_STORE]    = (lk_kind == ACC_STORE);
      fsr_n[FS_NF]       = (lk_kind == ACC_NFLOAD);
      fsr_n[FS_PM]       = lk_privmode;
      fsr_n[FS_CLS +: 2] = cls;
      fsr_n[FS_FT +: 3]  = r_ft;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_hit    <= 1'b0;
         res_fault  <= 1'b0;
         res_prot   <= 1'b0;
         res_miss   <= 1'b0;
         res_idx    <= '0;
         res_ppn    <= '0;
         res_perm   <= '0;
         res_ie     <= 1'b0;
         tag_access <= '0;
         fsr        <= '0;
         used_bits  <= '0;
      end else begin
         res_valid <= lk_valid;
         res_hit   <= lk_valid && clean;
         res_fault <= lk_valid && any_hit && r_fault;
         res_prot  <= lk_valid && any_hit && r_prot;
         res_miss  <= lk_valid && !any_hit;
         res_idx   <= (lk_valid && any_hit) ? pick : '0;
         res_ppn   <= (lk_valid && clean) ? merged_ppn : '0;
         res_perm  <= (lk_valid && clean) ? r_perm : 3'b000;
         res_ie    <= lk_valid && clean && sel_fl[FL_IE];
         if (lk_valid && !clean) tag_access <= ta_n;
         if (lk_valid && any_hit && (r_fault || r_prot)) fsr <= fsr_n;
         else if (fsr_clr) fsr <= '0;
         if (lk_valid && clean) used_bits[pick] <= 1'b1;
         if (wr_en) used_bits[wr_idx] <= 1'b0;
      end
   end
endmodule

// File: rtl/tlbx_chk.sv
module tlbx_chk
   import tlbx_pkg::*;
#(
   parameter int ENTRIES = 64,
   parameter int VA_W    = 64,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               lk_valid,
   input logic               wr_en,
   input logic [IDX_W-1:0]   wr_idx,
   input logic               fsr_clr,
   input logic               res_valid,
   input logic               res_hit,
   input logic               res_fault,
   input logic               res_prot,
   input logic               res_miss,
   input logic [IDX_W-1:0]   res_idx,
   input logic [2:0]         res_perm,
   input logic [VA_W-1:0]    tag_access,
   input logic [FSR_W-1:0]   fsr,
   input logic [ENTRIES-1:0] used_bits
);
   // R11
   lookup_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> res_valid);
   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !res_valid && !res_hit && !res_fault && !res_prot && !res_miss);
   // R11
   one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $onehot({res_hit, res_fault, res_prot, res_miss}));
   // R9
   no_rights_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_miss || res_fault || res_prot) |-> (res_perm == 3'b000));
   // R9
   hit_rights_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_hit |-> (res_perm != 3'b000));
   // R7
   hit_keeps_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_hit |-> $stable(tag_access));
   // R10
   fault_logged_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_fault || res_prot) |-> fsr[FS_VALID]);
   // R10
   miss_keeps_fsr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_miss && !$past(fsr_clr)) |-> $stable(fsr));
   // R8
   hit_marks_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_hit && !($past(wr_en) && ($past(wr_idx) == res_idx))) |-> used_bits[res_idx]);
endmodule

bind xlate_tlb tlbx_chk #(.ENTRIES(ENTRIES), .VA_W(VA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .lk_valid   (lk_valid),
   .wr_en      (wr_en),
   .wr_idx     (wr_idx),
   .fsr_clr    (fsr_clr),
   .res_valid  (res_valid),
   .res_hit    (res_hit),
   .res_fault  (res_fault),
   .res_prot   (res_prot),
   .res_miss   (res_miss),
   .res_idx    (res_idx),
   .res_perm   (res_perm),
   .tag_access (tag_access),
   .fsr        (fsr),
   .used_bits  (used_bits)
);

// File: tb/tb_xlate_tlb.sv
module tb_xlate_tlb;
   localparam int CLK_P = 10;
   localparam int NE = 64;

   localparam logic [6:0] F_V = 7'h01, F_G = 7'h02, F_P = 7'h04, F_W = 7'h08,
                          F_NFO = 7'h10, F_SE = 7'h20, F_IE = 7'h40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_P/2) clk = ~clk;

   logic        wr_en = 0;
   logic [5:0]  wr_idx = 0;
   logic [50:0] wr_vpn = 0;
   logic [12:0] wr_ctx = 0;
   logic [27:0] wr_ppn = 0;
   logic [1:0]  wr_size = 0;
   logic [6:0]  wr_flags = 0;
   logic        lk_valid = 0;
   logic [63:0] lk_va = 0;
   logic [1:0]  lk_kind = 0;
   logic        lk_user = 0;
   logic        lk_privmode = 0;
   logic [1:0]  lk_ctx_sel = 0;
   logic        lk_tl_nz = 0;
   logic [12:0] primary_ctx = 0;
   logic [12:0] secondary_ctx = 0;
   logic        fsr_clr = 0;
   logic        res_valid, res_hit, res_fault, res_prot, res_miss, res_ie;
   logic [5:0]  res_idx;
   logic [27:0] res_ppn;
   logic [2:0]  res_perm;
   logic [63:0] tag_access;
   logic [9:0]  fsr;
   logic [63:0] used_bits;

   xlate_tlb dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn),
      .wr_ctx(wr_ctx), .wr_ppn(wr_ppn), .wr_size(wr_size), .wr_flags(wr_flags),
      .lk_valid(lk_valid), .lk_va(lk_va), .lk_kind(lk_kind), .lk_user(lk_user),
      .lk_privmode(lk_privmode), .lk_ctx_sel(lk_ctx_sel), .lk_tl_nz(lk_tl_nz),
      .primary_ctx(primary_ctx), .secondary_ctx(secondary_ctx), .fsr_clr(fsr_clr),
      .res_valid(res_valid), .res_hit(res_hit), .res_fault(res_fault),
      .res_prot(res_prot), .res_miss(res_miss), .res_idx(res_idx),
      .res_ppn(res_ppn), .res_perm(res_perm), .res_ie(res_ie),
      .tag_access(tag_access), .fsr(fsr), .used_bits(used_bits)
   );

   // bench model of the table
   logic [50:0] m_tag [NE];
   logic [12:0] m_ctx [NE];
   logic [27:0] m_ppn [NE];
   logic [1:0]  m_size[NE];
   logic [6:0]  m_fl  [NE];
   logic [63:0] m_used = 0;
   logic [9:0]  m_fsr = 0;
   logic [63:0] m_ta = 0;

   int checks = 0;
   int errors = 0;

   task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic put(input int idx, input logic [63:0] va, input logic [12:0] c,
                      input logic [27:0] p, input logic [1:0] sz, input logic [6:0] fl);
      wr_en = 1; wr_idx = 6'(idx); wr_vpn = va[63:13]; wr_ctx = c;
      wr_ppn = p; wr_size = sz; wr_flags = fl;
      tick;
      wr_en = 0;
      m_tag[idx] = va[63:13]; m_ctx[idx] = c; m_ppn[idx] = p;
      m_size[idx] = sz; m_fl[idx] = fl; m_used[idx] = 1'b0;
   endtask

   task automatic clr;
      fsr_clr = 1;
      tick;
      fsr_clr = 0;
      m_fsr = 0;
      chk("R10", "fsr after clear", 64'(fsr), 64'(m_fsr));
   endtask

   task automatic look(input string rq, input logic [63:0] va, input logic [1:0] kind,
                       input logic user, input logic pm, input logic [1:0] sel, input logic tlnz);
      logic [12:0] ectx;
      logic [1:0]  ecls;
      logic [63:0] mask, pa;
      logic        found, fp, fe, fn, flt, prt, cln;
      int          hi;
      logic [6:0]  fl;
      logic [3:0]  e_out;
      logic [27:0] e_ppn;
      logic [2:0]  e_perm;
      logic [9:0]  nf;
      if (kind == 2'd3) begin
         ecls = tlnz ? 2'd2 : 2'd0;
      end else begin
         ecls = (sel == 2'd0) ? 2'd0 : (sel == 2'd1) ? 2'd1 : 2'd2;
      end
      ectx = (ecls == 2'd0) ? primary_ctx : (ecls == 2'd1) ? secondary_ctx : 13'd0;
      found = 0; hi = 0; mask = 0;
      for (int i = 0; i < NE; i++) begin
         logic [63:0] mk;
         mk = 64'd0 - (64'd8192 << (3 * m_size[i]));
         if (!found && m_fl[i][0] && (m_fl[i][1] || m_ctx[i] == ectx) &&
             ((va & mk) == ({m_tag[i], 13'h0} & mk))) begin
            found = 1; hi = i; mask = mk;
         end
      end
      fl  = found ? m_fl[hi] : 7'h0;
      fp  = found && user && fl[2];
      fe  = found && (kind == 2'd2) && fl[5];
      fn  = found && (kind < 2'd2) && fl[4];
      flt = fp || fe || fn;
      prt = found && !flt && (kind == 2'd1) && !fl[3];
      cln = found && !flt && !prt;
      e_out = {cln, flt, prt, !found};
      pa = found ? ((((64'(m_ppn[hi])) << 13) & mask) | (va & ~mask)) & 64'h1FF_FFFF_E000 : 64'h0;
      e_ppn  = cln ? pa[40:13] : 28'h0;
      e_perm = !cln ? 3'b000 : (kind == 2'd3) ? 3'b100 : (fl[3] ? 3'b011 : 3'b001);
      nf = {fn, fe, fp, ecls, pm, kind == 2'd2, kind == 2'd1, m_fsr[0], 1'b1};
      lk_valid = 1; lk_va = va; lk_kind = kind; lk_user = user; lk_privmode = pm;
      lk_ctx_sel = sel; lk_tl_nz = tlnz;
      tick;
      lk_valid = 0;
      if (!cln) m_ta = {va[63:13], 13'h0} | 64'(ectx);
      if (flt || prt) m_fsr = nf;
      if (cln) m_used[hi] = 1'b1;
      chk("R11", "res_valid", 64'(res_valid), 64'd1);
      chk(rq, "outcome hit/fault/prot/miss", 64'({res_hit, res_fault, res_prot, res_miss}), 64'(e_out));
      chk("R4", "res_idx", 64'(res_idx), found ? 64'(hi) : 64'd0);
      chk("R2", "res_ppn", 64'(res_ppn), 64'(e_ppn));
      chk("R9", "res_perm", 64'(res_perm), 64'(e_perm));
      chk("R9", "res_ie", 64'(res_ie), 64'(cln && fl[6]));
      chk("R7", "tag_access", tag_access, m_ta);
      chk("R10", "fsr", 64'(fsr), 64'(m_fsr));
      chk("R8", "used_bits", used_bits, m_used);
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      #(CLK_P * 100000);
      errors++; checks++;
      $display("FAIL watchdog expired");
      summary;
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'd2417);
      for (int i = 0; i < NE; i++) begin
         m_tag[i] = 0; m_ctx[i] = 0; m_ppn[i] = 0; m_size[i] = 0; m_fl[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R12 reset state
      chk("R12", "res_valid", 64'(res_valid), 0);
      chk("R12", "outcome", 64'({res_hit, res_fault, res_prot, res_miss}), 0);
      chk("R12", "tag_access", tag_access, 0);
      chk("R12", "fsr", 64'(fsr), 0);
      chk("R12", "used_bits", used_bits, 0);
      primary_ctx = 13'd5;
      look("R12", 64'h0000_1234_5678_A000, 2'd0, 0, 1, 2'd0, 0);

      // R1 basic match, context mismatch
      put(0, 64'h0000_1234_5678_A000, 13'd5, 28'h0AB_CDE1, 2'd0, F_V | F_W | F_IE);
      look("R1", 64'h0000_1234_5678_A123, 2'd0, 0, 1, 2'd0, 0);
      look("R1", 64'h0000_1234_5678_A000, 2'd1, 0, 1, 2'd0, 0);
      primary_ctx = 13'd6;
      look("R1", 64'h0000_1234_5678_A000, 2'd0, 0, 1, 2'd0, 0);
      // R11 idle cycle gives no result
      tick;
      chk("R11", "idle res_valid", 64'(res_valid), 0);
      // R2 global 4 MB page with low VA bits passed through
      put(1, 64'h0000_0000_7700_0000, 13'd9, 28'h012_3456, 2'd3, F_V | F_G);
      primary_ctx = 13'd2;
      look("R2", 64'h0000_0000_7733_5000, 2'd0, 0, 0, 2'd0, 0);
      look("R1", 64'h0000_0000_7F33_5000, 2'd0, 0, 0, 2'd0, 0);
      // R4 overlapping slots
      put(20, 64'h0000_0042_0000_0000, 13'd1, 28'h000_0020, 2'd0, F_V);
      put(10, 64'h0000_0042_0000_0000, 13'd1, 28'h000_0010, 2'd0, F_V);
      primary_ctx = 13'd1;
      look("R4", 64'h0000_0042_0000_0000, 2'd0, 0, 0, 2'd0, 0);
      // R5 privilege fault, R10 overflow and clear
      put(2, 64'h8000_0000_0000_0000, 13'd1, 28'h000_0002, 2'd1, F_V | F_P | F_W);
      look("R5", 64'h8000_0000_0000_4000, 2'd0, 1, 0, 2'd0, 0);
      look("R10", 64'h8000_0000_0000_4000, 2'd1, 1, 0, 2'd0, 0);
      clr;
      look("R10", 64'h8000_0000_0000_4000, 2'd3, 1, 0, 2'd0, 0);
      clr;
      look("R9", 64'h8000_0000_0000_4000, 2'd1, 0, 1, 2'd0, 0);
      // R5 side-effect and no-fault-only rules
      put(3, 64'h0000_0000_3000_0000, 13'd1, 28'h000_0003, 2'd0, F_V | F_SE);
      look("R5", 64'h0000_0000_3000_0000, 2'd2, 0, 1, 2'd0, 0);
      look("R9", 64'h0000_0000_3000_0000, 2'd0, 0, 1, 2'd0, 0);
      put(4, 64'h0000_0000_4000_0000, 13'd1, 28'h000_0004, 2'd2, F_V | F_NFO | F_W);
      look("R5", 64'h0000_0000_4001_2000, 2'd0, 0, 1, 2'd0, 0);
      look("R5", 64'h0000_0000_4001_2000, 2'd2, 0, 1, 2'd0, 0);
      look("R9", 64'h0000_0000_4001_2000, 2'd3, 0, 1, 2'd0, 0);
      // R5 several fault bits together
      put(9, 64'h0000_0000_9000_0000, 13'd1, 28'h000_0009, 2'd0, F_V | F_NFO | F_P);
      look("R5", 64'h0000_0000_9000_0000, 2'd1, 1, 0, 2'd0, 0);
      clr;
      // R6 protection fault vs privilege fault
      put(5, 64'h0000_0000_5000_0000, 13'd1, 28'h000_0005, 2'd0, F_V);
      look("R6", 64'h0000_0000_5000_0000, 2'd1, 0, 1, 2'd0, 0);
      put(6, 64'h0000_0000_6000_0000, 13'd1, 28'h000_0006, 2'd0, F_V | F_P);
      look("R6", 64'h0000_0000_6000_0000, 2'd1, 1, 0, 2'd0, 0);
      // R3 context selection
      put(7, 64'h0000_0000_0700_0000, 13'd3, 28'h000_0007, 2'd0, F_V);
      primary_ctx = 13'd1; secondary_ctx = 13'd3;
      look("R3", 64'h0000_0000_0700_0000, 2'd0, 0, 0, 2'd1, 0);
      look("R3", 64'h0000_0000_0700_0000, 2'd0, 0, 0, 2'd0, 0);
      look("R3", 64'h0000_0000_0700_0000, 2'd0, 0, 0, 2'd2, 0);
      put(8, 64'h0000_0000_0800_0000, 13'd0, 28'h000_0008, 2'd0, F_V);
      primary_ctx = 13'd4;
      look("R3", 64'h0000_0000_0800_0000, 2'd3, 0, 1, 2'd0, 1);
      look("R3", 64'h0000_0000_0800_0000, 2'd3, 0, 1, 2'd0, 0);
      look("R3", 64'h0000_0000_0800_0000, 2'd0, 0, 1, 2'd3, 0);
      // R8 rewrite clears used bit
      put(0, 64'h0000_1234_5678_A000, 13'd5, 28'h0AB_CDE1, 2'd0, F_V);
      chk("R8", "used after rewrite", used_bits, m_used);

      // random phase
      for (int i = 0; i < NE; i++) begin
         logic [63:0] va;
         logic [6:0]  fl;
         va = {35'h0, 8'($urandom_range(0, 15)), 9'($urandom), 12'h0};
         fl = 7'($urandom) | (($urandom_range(0, 9) != 0) ? F_V : 7'h0);
         put(i, va, 13'($urandom_range(0, 3)), 28'($urandom), 2'($urandom), fl);
      end
      for (int n = 0; n < 400; n++) begin
         int          s;
         logic [63:0] va;
         s = $urandom_range(0, NE - 1);
         va = {m_tag[s], 13'h0} ^ 64'($urandom_range(0, 32'h3F_FFFF));
         primary_ctx = 13'($urandom_range(0, 3));
         secondary_ctx = 13'($urandom_range(0, 3));
         if ($urandom_range(0, 15) == 0) clr;
         look("R1", va, 2'($urandom), 1'($urandom), 1'($urandom),
              2'($urandom), 1'($urandom));
      end

      summary;
      $finish;
   end
endmodule